// File: doc/BRIEF.md
# Receive Robbed-Bit Signaling Capture

This block takes the per-channel byte stream of a 24-channel T1 receiver. It pulls the robbed-bit signaling out of the signaling frames and presents it to a host as twelve 8-bit registers through a combinational address/data read port.

Bits are collected in a shadow set while a multiframe is arriving. At the multiframe boundary strobe, the shadow set is copied to the visible registers in one cycle. A one-cycle interrupt pulse then tells the host that fresh values can be read.

In the four-bit (ESF) mode, each channel yields A, B, C and D. In the two-bit (D4) mode, only A and B arrive. The C and D slots then show the A and B values of the previous multiframe, so a host that reads once every 3 ms sees every bit in either mode.

While loss of sync is flagged, the visible registers hold the last good values. They stay held until one clean boundary has passed.

Top module: `rbs_capture`

## Requirements
- R1: Read address k (0 to 11) returns register k+1. Addresses 0–2 hold A, 3–5 hold B, 6–8 hold A/C and 9–11 hold B/D. Bit i of address k belongs to channel 8*(k mod 3)+i+1, where channel 1 is ts_chan 0.
- R2: With mode_esf=1, bit 0 of each channel byte in frames 6, 12, 18 and 24 is captured as A, B, C and D respectively.
- R3: With mode_esf=0, bit 0 in frames 6 and 12 is captured as A and B. At a committing boundary, the C/D registers take the A/B register values that were visible before that boundary.
- R4: The visible registers change only on the clock edge that samples mf_strobe high. Between boundaries, reads return the previously committed values.
- R5: mf_irq is high for exactly one cycle, in the cycle after every mf_strobe, whether or not sync is lost.
- R6: While los is high, the visible registers are not updated, including at a boundary strobed with los high.
- R7: After los has been high, the first boundary strobed with los low commits nothing and ends the freeze. The boundary after it commits normally.
- R8: Channel bytes in frames other than the signaling frames of the current mode, and bits 7..1 of every byte, leave the registers unchanged.
- R9: After reset, all twelve registers read 0 and mf_irq is low.
- R10: Read addresses 12 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | A channel byte is present this cycle |
| ts_chan | input | 5 | Channel index, 0 to 23 |
| ts_byte | input | 8 | Channel byte; bit 0 carries the robbed bit |
| frame_num | input | 5 | Frame number within the multiframe, from 1 |
| mode_esf | input | 1 | 1: four-bit mode, 0: two-bit mode |
| mf_strobe | input | 1 | Multiframe boundary, one cycle |
| los | input | 1 | Loss-of-sync flag |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| mf_irq | output | 1 | Multiframe interrupt pulse |

## Verification
The hardest state to reach is the release after a freeze. It needs a multiframe with loss of sync in it, then a boundary with sync restored that must still commit nothing, and then a boundary that commits. The D4 fold must also pick up the values that were visible before the freeze rather than the lost shadow data. The stimulus reaches this with multiframe runs that raise los over a few frames, or over a whole multiframe including its strobe, each followed by clean runs. A read probe in the middle of every multiframe confirms that nothing moves between boundaries.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int CHANNELS   = 24;
    localparam int BYTE_W     = 8;
    localparam int SLOTS      = 4;
    localparam int D4_SLOTS   = 2;
    localparam int SIG_PERIOD = 6;
    localparam int FRAME_W    = 5;
    localparam int CH_W       = $clog2(CHANNELS);
    localparam int PARTS      = CHANNELS / BYTE_W;
    localparam int REGS       = SLOTS * PARTS;
    localparam int ADDR_W     = $clog2(REGS);

    // index 0..3 = A, B, C (or folded A), D (or folded B)
    typedef logic [SLOTS-1:0][CHANNELS-1:0] sig_bank_t;

    typedef struct packed {
        logic              valid;
        logic [CH_W-1:0]   chan;
        logic [BYTE_W-1:0] data;
    } ts_beat_t;

    function automatic logic slot_hit(input logic [FRAME_W-1:0] frame,
                                      input logic esf, input int slot);
        return (frame == FRAME_W'(SIG_PERIOD * (slot + 1))) &&
               (esf || (slot < D4_SLOTS));
    endfunction
endpackage

// File: rtl/rbs_extract.sv
module rbs_extract
    import rbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ts_beat_t           beat,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               mode_esf,
    output sig_bank_t          shadow
);
    logic chan_ok;
    assign chan_ok = beat.valid && (beat.chan < CH_W'(CHANNELS));

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[s] <= '0;
            end else if (chan_ok && slot_hit(frame_num, mode_esf, s)) begin
                shadow[s][beat.chan] <= beat.data[0];
            end
        end
    end
endmodule

// File: rtl/rbs_commit.sv
module rbs_commit
    import rbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mf_strobe,
    input  logic      mode_esf,
    input  logic      los,
    input  sig_bank_t shadow,
    output sig_bank_t visible,
    output logic      frozen,
    output logic      mf_irq
);
    logic do_commit;
    assign do_commit = mf_strobe && !los && !frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            visible <= '0;
            frozen  <= 1'b0;
            mf_irq  <= 1'b0;
        end else begin
            mf_irq <= mf_strobe;
            if (los) begin
                frozen <= 1'b1;
            end else if (mf_strobe && frozen) begin
                frozen <= 1'b0;
            end
            if (do_commit) begin
                visible[0] <= shadow[0];
                visible[1] <= shadow[1];
                visible[2] <= mode_esf ? shadow[2] : visible[0];
                visible[3] <= mode_esf ? shadow[3] : visible[1];
            end
        end
    end
endmodule

// File: rtl/rbs_readmux.sv
module rbs_readmux
    import rbs_pkg::*;
(
    input  sig_bank_t         bank,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data
);
    logic [BYTE_W-1:0] regs [REGS];

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        assign regs[r] = bank[r / PARTS][(r % PARTS) * BYTE_W +: BYTE_W];
    end

    always_comb begin
        data = '0;
        if (addr < ADDR_W'(REGS)) data = regs[addr];
    end
endmodule

// File: rtl/rbs_capture.sv
module rbs_capture
    import rbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ts_valid,
    input  logic [CH_W-1:0]    ts_chan,
    input  logic [BYTE_W-1:0]  ts_byte,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               mode_esf,
    input  logic               mf_strobe,
    input  logic               los,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               mf_irq
);
    ts_beat_t  beat;
    sig_bank_t shadow_bank;
    sig_bank_t vis_bank;
    logic      frozen;

    assign beat = '{valid: ts_valid, chan: ts_chan, data: ts_byte};

    rbs_extract u_extract (
        .clk(clk), .rst(rst), .beat(beat), .frame_num(frame_num),
        .mode_esf(mode_esf), .shadow(shadow_bank)
    );

    rbs_commit u_commit (
        .clk(clk), .rst(rst), .mf_strobe(mf_strobe), .mode_esf(mode_esf),
        .los(los), .shadow(shadow_bank), .visible(vis_bank),
        .frozen(frozen), .mf_irq(mf_irq)
    );

    rbs_readmux u_readmux (
        .bank(vis_bank), .addr(rd_addr), .data(rd_data)
    );
endmodule

// File: rtl/rbs_capture_chk.sv
module rbs_capture_chk
    import rbs_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      mf_strobe,
    input logic      mode_esf,
    input logic      los,
    input logic      mf_irq,
    input logic      frozen,
    input sig_bank_t vis,
    input sig_bank_t sh
);
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
        mf_strobe |=> mf_irq);
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
        !mf_strobe |=> !mf_irq);
    assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
        !mf_strobe |=> $stable(vis));
    assert_freeze_los_R6: assert property (@(posedge clk) disable iff (rst)
        los |=> $stable(vis));
    assert_release_skip_R7: assert property (@(posedge clk) disable iff (rst)
        (mf_strobe && !los && frozen) |=> ($stable(vis) && !frozen));
    assert_fold_d4_R3: assert property (@(posedge clk) disable iff (rst)
        (mf_strobe && !mode_esf && !los && !frozen) |=>
            (vis[2] == $past(vis[0]) && vis[3] == $past(vis[1])));
    assert_esf_commit_R2: assert property (@(posedge clk) disable iff (rst)
        (mf_strobe && mode_esf && !los && !frozen) |=>
            (vis[3] == $past(sh[3]) && vis[0] == $past(sh[0])));
endmodule

bind rbs_capture rbs_capture_chk u_chk (
    .clk(clk), .rst(rst), .mf_strobe(mf_strobe), .mode_esf(mode_esf),
    .los(los), .mf_irq(mf_irq), .frozen(frozen), .vis(vis_bank),
    .sh(shadow_bank)
);

// File: tb/tb_rbs_capture.sv
`timescale 1ns/1ps
module tb_rbs_capture;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ts_valid = 1'b0;
    logic [4:0] ts_chan = '0;
    logic [7:0] ts_byte = '0;
    logic [4:0] frame_num = '0;
    logic       mode_esf = 1'b1;
    logic       mf_strobe = 1'b0;
    logic       los = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       mf_irq;
    logic       probe = 1'b0;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    int irq_seen = 0;

    typedef struct {
        logic [7:0] exp;
        int         addr;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    logic [3:0][23:0] sh_m  = '0;
    logic [3:0][23:0] vis_m = '0;
    bit frozen_m = 1'b0;

    always #2.5 clk = ~clk;

    rbs_capture dut (
        .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_chan(ts_chan),
        .ts_byte(ts_byte), .frame_num(frame_num), .mode_esf(mode_esf),
        .mf_strobe(mf_strobe), .los(los), .rd_addr(rd_addr),
        .rd_data(rd_data), .mf_irq(mf_irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R1 layout: group = addr/3 (A,B,C,D), bit i = channel 8*(addr%3)+i
    function automatic logic [7:0] reg_of(input logic [3:0][23:0] b, input int k);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = b[k / 3][8 * (k % 3) + i];
        return v;
    endfunction

    task automatic push_all(input string tag);
        for (int k = 0; k < 12; k++) begin
            exp_t it;
            it.exp = reg_of(vis_m, k);
            it.addr = k;
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_mf(input bit esf, input int los_lo, input int los_hi,
                          input bit los_strobe, input string tag);
        int nfr = esf ? 24 : 12;
        for (int f = 1; f <= nfr; f++) begin
            for (int c = 0; c < 24; c++) begin
                tick();
                los = (f >= los_lo) && (f <= los_hi);
                if (los) frozen_m = 1'b1;
                mode_esf = esf;
                frame_num = 5'(f);
                ts_valid = 1'b1;
                ts_chan = 5'(c);
                ts_byte = 8'($urandom);
                if (f % 6 == 0 && (f / 6 - 1) < (esf ? 4 : 2))
                    sh_m[f / 6 - 1][c] = ts_byte[0];
            end
            if (f == 9) begin
                // R4: mid-multiframe read must show the last committed values
                tick();
                ts_valid = 1'b0;
                probe = 1'b1;
                push_all("R4");
                tick();
                probe = 1'b0;
            end
        end
        tick();
        ts_valid = 1'b0;
        los = los_strobe;
        mf_strobe = 1'b1;
        if (los_strobe) begin
            frozen_m = 1'b1;
        end else if (frozen_m) begin
            frozen_m = 1'b0;
        end else begin
            logic [3:0][23:0] nv;
            nv[0] = sh_m[0];
            nv[1] = sh_m[1];
            nv[2] = esf ? sh_m[2] : vis_m[0];
            nv[3] = esf ? sh_m[3] : vis_m[1];
            vis_m = nv;
        end
        push_all(tag);
        strobes++;
        tick();
        mf_strobe = 1'b0;
        los = 1'b0;
    endtask

    task automatic monitor();
        bit prev_irq = 1'b0;
        forever begin
            @(negedge clk);
            if (mf_irq) irq_seen++;
            if (mf_irq && prev_irq) begin
                checks++;
                fails++;
                $display("FAIL R5: irq width actual 2+ expected 1");
            end
            prev_irq = mf_irq;
            if (mf_irq || probe) begin
                for (int k = 0; k < 12; k++) begin
                    exp_t it;
                    if (sb_q.size() == 0) begin
                        checks++;
                        fails++;
                        $display("FAIL R5: read event with empty queue actual 0 expected 1");
                        break;
                    end
                    it = sb_q.pop_front();
                    rd_addr = 4'(it.addr);
                    #0.1;
                    check(rd_data, it.exp, it.tag);
                end
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check({7'b0, mf_irq}, 8'h00, "R9");
        for (int k = 0; k < 16; k++) begin
            rd_addr = 4'(k);
            #0.1;
            check(rd_data, 8'h00, k < 12 ? "R9" : "R10");
        end
        fork
            monitor();
        join_none
        run_mf(1, 99, 0, 0, "R1");
        run_mf(1, 99, 0, 0, "R2");
        run_mf(0, 99, 0, 0, "R3");
        run_mf(0, 99, 0, 0, "R3");
        run_mf(1, 99, 0, 0, "R2");
        run_mf(0, 3, 5, 0, "R6");
        run_mf(0, 99, 0, 0, "R7");
        run_mf(1, 1, 24, 1, "R6");
        run_mf(1, 99, 0, 0, "R7");
        run_mf(1, 99, 0, 0, "R8");
        run_mf(0, 99, 0, 0, "R3");
        repeat (5) tick();
        // R10: out-of-range addresses after data has been committed
        for (int k = 12; k < 16; k++) begin
            @(negedge clk);
            rd_addr = 4'(k);
            #0.1;
            check(rd_data, 8'h00, "R10");
        end
        check(8'(sb_q.size()), 8'h00, "R5");
        check(8'(irq_seen), 8'(strobes), "R5");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule